// File: doc/BRIEF.md
# Transparent, Latched or Clocked Word Stage

This block is the storage stage for one direction of a bidirectional bus transceiver. It carries an 18-bit word made of 16 data bits and one parity bit per byte. The word moves from an input side to an output side. Two control inputs pick the behaviour: a latch-open input makes the stage transparent, and a capture strobe loads the word on its rising edge while the latch is closed. With the latch closed and the strobe steady, the stage holds its word. An active-low output enable either drives the stored or live word, or releases the output. The release is modelled as a separate drive flag, with the output value forced to zero.

The stage runs on a system clock `clk`. The capture strobe is an ordinary input that is sampled at every `clk` rising edge. A strobe "rising edge" means the strobe was sampled low at one `clk` edge and high at the next. The transparent path is combinational from the inputs to the outputs. A captured or retained word reaches the outputs right after the `clk` edge that stores it. Parity bits are carried through without change and are never computed or checked here.

Top module: `hold_stage`

## Requirements
- R1: The word has 16 data bits and 2 parity bits. Parity bit k (`din_par[k]`) travels with data byte k (`din_data[8k+7:8k]`) and reaches `dout_par[k]` unchanged, whatever the data holds.
- R2: While `lat_open` is 1 and `out_en_n` is 0, `dout_data`/`dout_par` equal `din_data`/`din_par` in the same cycle, whatever `strobe` does.
- R3: With `lat_open` at 0, a strobe rising edge at a `clk` edge stores the word present at that edge. The word appears on the outputs from just after that edge.
- R4: With `lat_open` at 0 and `strobe` steady (low or high), the outputs keep their previous word whatever the inputs do.
- R5: While `lat_open` is 1 the store follows the input. When `lat_open` falls with `strobe` already high, the word present at the last `clk` edge with `lat_open` at 1 is kept until the strobe goes low and rises again. When `lat_open` falls with `strobe` low, the next strobe rise replaces that word.
- R6: While `out_en_n` is 1, `dout_drive` is 0 and `dout_data`/`dout_par` are all zeros, whatever the other inputs are. While `out_en_n` is 0, `dout_drive` is 1.
- R7: `out_en_n` has no effect on storage. A word captured while the output is released appears as soon as `out_en_n` returns to 0.
- R8: A synchronous active-low reset clears the stored word to zeros. The strobe edge reference keeps following `strobe` during reset, so a strobe that is already high when reset ends is not an edge.
- R9: A strobe rise while `lat_open` is 1 has no effect of its own. After `lat_open` falls with the strobe still high, no further capture takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lat_open | input | 1 | 1 = transparent, 0 = latch closed |
| strobe | input | 1 | Capture strobe, sampled at each `clk` edge |
| out_en_n | input | 1 | Output enable, active low |
| din_data | input | 16 | Input data word |
| din_par | input | 2 | Input parity, one bit per byte |
| dout_data | output | 16 | Output data, zero while released |
| dout_par | output | 2 | Output parity, zero while released |
| dout_drive | output | 1 | 1 when the output is driven, 0 when high impedance |

## Verification
On every cycle the assertions check the transparent path, capture on a sampled strobe rise, steady holding with a closed latch, the word kept when the latch closes, the released output, and the cleared word after reset. Only the bench's scenarios show some of the behaviour. These are the order-dependent retention rule (latch closing with the strobe high versus low), a strobe rise hidden inside the open window, a capture made while the output is released and seen only once it is enabled, and byte-to-parity lane pairing under walking patterns. A long pseudo-random sweep of all control combinations is compared with an arithmetic model of the requirements.

// File: rtl/hs_pkg.sv
// Package for the word stage: default geometry and the storage mode encoding.
// Assumes the data width is a whole number of parity lanes.
package hs_pkg;

    localparam int HS_DATA_W_DEF = 16;
    localparam int HS_LANE_W_DEF = 8;

    // What the store does at the next clk edge.
    typedef enum logic [1:0] {
        HS_HOLD    = 2'd0,
        HS_TRACK   = 2'd1,
        HS_CAPTURE = 2'd2
    } hs_mode_e;

    // Number of parity lanes for a given data and lane width.
    function automatic int hs_lanes(input int data_w, input int lane_w);
        return data_w / lane_w;
    endfunction

endpackage

// File: rtl/hs_strobe_edge.sv
// Strobe edge finder: reports a rising strobe as seen by two consecutive clk
// samples. Assumes the strobe is already synchronous to clk. The reference
// flop has no reset, so it follows the strobe during reset and no edge is
// reported when reset ends with the strobe already high.
module hs_strobe_edge (
    input  logic clk,
    input  logic strobe,
    output logic rise
);

    logic strobe_q;

    // Keep the strobe value from the previous clk edge.
    always_ff @(posedge clk) begin
        strobe_q <= strobe;
    end

    // A rise is a high sample that follows a low one.
    always_comb begin
        rise = strobe & ~strobe_q;
    end

endmodule

// File: rtl/hs_mode_dec.sv
// Mode decoder: picks what the store does at the next clk edge. An open latch
// takes priority over the strobe, and a strobe rise counts only while the
// latch is closed. Assumes rise comes from hs_strobe_edge.
module hs_mode_dec
    import hs_pkg::*;
(
    input  logic     lat_open,
    input  logic     rise,
    output hs_mode_e mode,
    output logic     load
);

    // Priority: open latch, then strobe rise, else hold.
    always_comb begin
        if (lat_open) begin
            mode = HS_TRACK;
        end else if (rise) begin
            mode = HS_CAPTURE;
        end else begin
            mode = HS_HOLD;
        end
    end

    // Any mode other than hold writes the store.
    always_comb begin
        load = (mode != HS_HOLD);
    end

endmodule

// File: rtl/hs_store_lane.sv
// One lane of storage: a byte of data plus its parity bit. Clears on a
// synchronous active-low reset and loads when told to. Assumes load is
// already qualified by the mode decoder.
module hs_store_lane #(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LANE_W-1:0] d_data,
    input  logic              d_par,
    output logic [LANE_W-1:0] q_data,
    output logic              q_par
);

    // Store the lane word, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_data <= '0;
            q_par  <= 1'b0;
        end else if (load) begin
            q_data <= d_data;
            q_par  <= d_par;
        end
    end

endmodule

// File: rtl/hs_out_stage.sv
// Output stage: selects the live input while the latch is open, otherwise the
// stored word, and forces zero with the drive flag low while released.
// Assumes the live and held words share one packing.
module hs_out_stage #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              sel_live,
    input  logic              out_en_n,
    input  logic [DATA_W-1:0] live_data,
    input  logic [LANES-1:0]  live_par,
    input  logic [DATA_W-1:0] held_data,
    input  logic [LANES-1:0]  held_par,
    output logic [DATA_W-1:0] o_data,
    output logic [LANES-1:0]  o_par,
    output logic              o_drive
);

    logic [DATA_W-1:0] pick_data;
    logic [LANES-1:0]  pick_par;

    // Transparent bypass or stored word.
    always_comb begin
        pick_data = sel_live ? live_data : held_data;
        pick_par  = sel_live ? live_par  : held_par;
    end

    // Drive or release the output.
    always_comb begin
        o_drive = ~out_en_n;
        o_data  = o_drive ? pick_data : '0;
        o_par   = o_drive ? pick_par  : '0;
    end

endmodule

// File: rtl/hold_stage.sv
// Word stage top: strobe edge finder, mode decoder, one store lane per
// parity byte, and the output stage. Assumes DATA_W is a multiple of LANE_W
// and that all inputs are synchronous to clk.
module hold_stage
    import hs_pkg::*;
#(
    parameter int DATA_W = HS_DATA_W_DEF,
    parameter int LANE_W = HS_LANE_W_DEF
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                lat_open,
    input  logic                                strobe,
    input  logic                                out_en_n,
    input  logic [DATA_W-1:0]                   din_data,
    input  logic [hs_lanes(DATA_W, LANE_W)-1:0] din_par,
    output logic [DATA_W-1:0]                   dout_data,
    output logic [hs_lanes(DATA_W, LANE_W)-1:0] dout_par,
    output logic                                dout_drive
);

    localparam int LANES = hs_lanes(DATA_W, LANE_W);

    logic              strobe_rise;
    logic              store_load;
    hs_mode_e          store_mode;
    logic [DATA_W-1:0] held_data;
    logic [LANES-1:0]  held_par;

    hs_strobe_edge u_edge (
        .clk    (clk),
        .strobe (strobe),
        .rise   (strobe_rise)
    );

    hs_mode_dec u_mode (
        .lat_open (lat_open),
        .rise     (strobe_rise),
        .mode     (store_mode),
        .load     (store_load)
    );

    // One storage lane per parity byte.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        hs_store_lane #(
            .LANE_W (LANE_W)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (store_load),
            .d_data (din_data[g*LANE_W +: LANE_W]),
            .d_par  (din_par[g]),
            .q_data (held_data[g*LANE_W +: LANE_W]),
            .q_par  (held_par[g])
        );
    end

    hs_out_stage #(
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_out (
        .sel_live  (lat_open),
        .out_en_n  (out_en_n),
        .live_data (din_data),
        .live_par  (din_par),
        .held_data (held_data),
        .held_par  (held_par),
        .o_data    (dout_data),
        .o_par     (dout_par),
        .o_drive   (dout_drive)
    );

endmodule

// File: rtl/hs_stage_chk.sv
// Checker for hold_stage, attached by bind. It watches only ports and
// relates them across clk edges.
module hs_stage_chk #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lat_open,
    input logic              strobe,
    input logic              out_en_n,
    input logic [DATA_W-1:0] din_data,
    input logic [LANES-1:0]  din_par,
    input logic [DATA_W-1:0] dout_data,
    input logic [LANES-1:0]  dout_par,
    input logic              dout_drive
);

    AST_TRACK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_open && !out_en_n) |-> (dout_data == din_data && dout_par == din_par)); // R2

    AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!lat_open && $rose(strobe)) |=>
        (lat_open || out_en_n || (dout_data == $past(din_data) && dout_par == $past(din_par)))); // R3

    AST_STEADY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!lat_open && !$rose(strobe) && !out_en_n) |=>
        (lat_open || out_en_n || ($stable(dout_data) && $stable(dout_par)))); // R4

    AST_CLOSE_KEEPS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lat_open) && $past(rst_n) && !out_en_n) |->
        (dout_data == $past(din_data) && dout_par == $past(din_par))); // R5

    AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> (!dout_drive && dout_data == '0 && dout_par == '0)); // R6

    AST_DRIVE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_n |-> dout_drive); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && !lat_open && !out_en_n) |->
        (dout_data == '0 && dout_par == '0)); // R8

endmodule

bind hold_stage hs_stage_chk #(
    .DATA_W (DATA_W),
    .LANES  (LANES)
) u_hs_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lat_open   (lat_open),
    .strobe     (strobe),
    .out_en_n   (out_en_n),
    .din_data   (din_data),
    .din_par    (din_par),
    .dout_data  (dout_data),
    .dout_par   (dout_par),
    .dout_drive (dout_drive)
);

// File: tb/test_hold_stage.sv
// Bench for hold_stage: directed mode scenarios plus a long pseudo-random
// sweep, compared against an arithmetic model of the requirements.
module test_hold_stage;

    localparam int DW = 16;
    localparam int NL = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lat_open = 1'b0;
    logic          strobe = 1'b0;
    logic          out_en_n = 1'b0;
    logic [DW-1:0] din_data = '0;
    logic [NL-1:0] din_par = '0;
    logic [DW-1:0] dout_data;
    logic [NL-1:0] dout_par;
    logic          dout_drive;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state, from the requirements.
    logic [DW-1:0] m_data = '0;
    logic [NL-1:0] m_par = '0;
    logic          m_prev = 1'b0;
    logic          m_cap = 1'b0;
    logic [31:0]   lfsr = 32'h1ACE_B00C;

    always #10 clk = ~clk;

    hold_stage i_hold_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .lat_open   (lat_open),
        .strobe     (strobe),
        .out_en_n   (out_en_n),
        .din_data   (din_data),
        .din_par    (din_par),
        .dout_data  (dout_data),
        .dout_par   (dout_par),
        .dout_drive (dout_drive)
    );

    function automatic logic [31:0] nxt(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] ed, input logic [NL-1:0] ep,
                       input logic edr);
        checks++;
        if (dout_data !== ed || dout_par !== ep || dout_drive !== edr) begin
            errors++;
            $display("FAIL %s: data %h par %b drive %b, expected data %h par %b drive %b",
                     tag, dout_data, dout_par, dout_drive, ed, ep, edr);
        end
    endtask

    // Apply one cycle of inputs, check the outputs, then advance the model.
    task automatic step(input logic le, input logic stb, input logic oen,
                        input logic [DW-1:0] d, input logic [NL-1:0] p,
                        input string tag = "");
        logic [DW-1:0] ed;
        logic [NL-1:0] ep;
        string t;
        @(negedge clk);
        lat_open = le; strobe = stb; out_en_n = oen; din_data = d; din_par = p;
        #1;
        ed = oen ? '0 : (le ? d : m_data);
        ep = oen ? '0 : (le ? p : m_par);
        if (tag != "") t = tag;
        else if (oen) t = "R6";
        else if (le) t = "R2";
        else if (m_cap) t = "R3";
        else t = "R4";
        chk(t, ed, ep, !oen);
        @(posedge clk);
        if (!rst_n) begin
            m_data = '0; m_par = '0; m_cap = 1'b0;
        end else begin
            m_cap = !le && stb && !m_prev;
            if (le || m_cap) begin
                m_data = d; m_par = p;
            end
        end
        m_prev = stb;
    endtask

    initial begin
        // Reset: transparent path still live, store cleared (R8).
        step(1, 0, 0, 16'hA5C3, 2'b10, "R2");
        step(0, 1, 0, 16'h1234, 2'b01, "R8");
        step(0, 1, 1, 16'h4321, 2'b11, "R6");
        rst_n = 1'b1;
        // Strobe high when reset ends: no edge (R8).
        step(0, 1, 0, 16'hBEEF, 2'b11, "R8");
        step(0, 1, 0, 16'hCAFE, 2'b10, "R8");

        // Capture on a rise, then hold at steady low and high (R3, R4).
        step(0, 0, 0, 16'h0F0F, 2'b00, "R4");
        step(0, 1, 0, 16'h5555, 2'b01, "R4");
        step(0, 1, 0, 16'h9999, 2'b10, "R3");
        step(0, 0, 0, 16'h7777, 2'b11, "R4");
        step(0, 0, 0, 16'h6666, 2'b00, "R4");

        // Latch closes with strobe high: last open word kept (R5).
        step(1, 1, 0, 16'hAAAA, 2'b01, "R2");
        step(0, 1, 0, 16'hBBBB, 2'b10, "R5");
        step(0, 1, 0, 16'hCCCC, 2'b11, "R5");
        // Latch closes with strobe low: next rise replaces it (R5).
        step(1, 0, 0, 16'hD00D, 2'b10, "R2");
        step(0, 0, 0, 16'hE00E, 2'b01, "R5");
        step(0, 1, 0, 16'hF00F, 2'b11, "R5");
        step(0, 1, 0, 16'h1111, 2'b00, "R5");

        // Rise inside the open window is not a later capture (R9).
        step(1, 0, 0, 16'h2222, 2'b00, "R9");
        step(1, 1, 0, 16'h3333, 2'b01, "R9");
        step(0, 1, 0, 16'h4444, 2'b10, "R9");
        step(0, 1, 0, 16'h5A5A, 2'b11, "R9");

        // Capture while released, seen once enabled (R6, R7).
        step(0, 0, 1, 16'h0000, 2'b00, "R6");
        step(0, 1, 1, 16'h8181, 2'b10, "R6");
        step(0, 1, 0, 16'h0000, 2'b00, "R7");

        // Lane pairing with walking patterns (R1).
        for (int k = 0; k < DW; k++) begin
            step(1, 0, 0, 16'h1 << k, 2'(k % 4), "R1");
        end
        step(1, 0, 0, 16'h00FF, 2'b10, "R1");
        step(1, 0, 0, 16'hFF00, 2'b01, "R1");

        // Exhaustive control walk, then a pseudo-random sweep.
        for (int i = 0; i < 64; i++) begin
            lfsr = nxt(lfsr);
            step(i[0], i[1] ^ i[3], i[2] & i[4], lfsr[15:0], lfsr[17:16]);
        end
        for (int i = 0; i < 3000; i++) begin
            lfsr = nxt(lfsr);
            step(lfsr[20] & lfsr[21], lfsr[22], lfsr[23] & lfsr[24] & lfsr[25],
                 lfsr[15:0], lfsr[17:16]);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run incomplete, all requirements, actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule